// File: doc/BRIEF.md
# Read Buffer Pool Allocator

This block owns a pool of sixteen read response buffers that are shared by eight bus slots, where each slot can use a normal channel and a virtual channel. Ownership is kept in two 32-bit map words. Each word is split into eight 4-bit fields, one per buffer. A field's top bit marks the buffer as enabled. Its low three bits name the owner. Buffer number b lives in word b mod 2, at field b div 2.

A command port takes one request at a time through a valid/ready handshake. A request can count the buffers a requester owns, count the free buffers, claim up to N free buffers, release up to N owned buffers, or flush a single buffer. When buffers are released or flushed, the block runs a drain handshake against the buffer status lines before it reports completion. It waits for in-flight responses to finish, then strobes a clear for any buffer that still holds data and waits until that data is gone. Each command ends with a one-cycle done pulse that carries a count and a pass flag.

Top module: `rdbuf_pool_alloc`

## Requirements
- R1: A synchronous active-high reset frees all sixteen buffers, so count-free on either word returns 8. It also raises cmd_ready, and holds rsp_done and every buf_clear bit low.
- R2: A requester id is 4 bits. Bit 3 is the virtual-channel flag and bits 2:0 are the slot. Id bit 0 selects map word 0 or 1. The enabled owner code is 8 + (id >> 1), so the virtual flag sits in code bit 2 and the slot-pair index in code bits 1:0.
- R3: Op 1 (count-free) returns the number of fields in the selected word whose enable bit (bit 3) is clear. The result lies between 0 and 8, and rsp_ok is 1.
- R4: Op 0 (count-owned) returns the number of fields in the selected word whose full 4-bit value equals the requester's owner code, and rsp_ok is 1.
- R5: Op 2 (claim, N = cmd_num) writes the owner code into free fields in ascending field order until N are claimed. If fewer than N fields are free, the claims already made are kept and rsp_ok is 0. rsp_count is the number of fields claimed. N = 0 claims nothing and passes.
- R6: Op 3 (release, N = cmd_num) clears the enable bit of fields equal to the owner code, lowest field first, stopping at N. If fewer than N are owned, all owned fields are released and rsp_ok is 0. rsp_count is the number released.
- R7: Released buffers are drained one after another in ascending buffer number (2 × field + word). For each one, the block waits until buf_inuse[b] is low. Then, only if buf_valid[b] is high, it pulses buf_clear[b] for one cycle and waits until buf_valid[b] falls. At most one buf_clear bit is high at a time.
- R8: Op 4 (flush, cmd_num = buffer number b) disables field b div 2 of word b mod 2. It then runs the R7 drain for buffer b and afterwards restores the field's original value. rsp_count is 0 and rsp_ok is 1.
- R9: cmd_ready is high only when the block is idle, and it falls in the cycle after a command is accepted. rsp_done is a single-cycle pulse. When no buffer has to be drained, rsp_done is high in the second cycle after acceptance. No buf_clear is issued while cmd_ready is high.
- R10: Op codes 5 to 7 change no field. They complete with rsp_count 0 and rsp_ok 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block is idle and accepts a command |
| cmd_op | input | 3 | Operation code (0 count-owned, 1 count-free, 2 claim, 3 release, 4 flush) |
| cmd_id | input | 4 | Requester: virtual flag in bit 3, slot in bits 2:0 |
| cmd_num | input | 4 | Amount N for claim/release, buffer number for flush |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_count | output | 4 | Result count, valid with rsp_done |
| rsp_ok | output | 1 | Pass flag, valid with rsp_done |
| buf_inuse | input | 16 | Per-buffer indication that responses are still in flight |
| buf_valid | input | 16 | Per-buffer indication that data is held |
| buf_clear | output | 16 | Per-buffer clear strobe |

## Verification
The hardest case to reach is a multi-buffer release in which the buffers are in different states. One buffer still has responses in flight, one holds data, and one is already empty, so the drain must stall, strobe and skip in ascending order within a single command. The bench first claims buffers for several requesters to fill the map words. Before each release it sets the status lines directly, giving chosen buffers an in-use countdown and held data. It then checks each clear strobe against a queue of expected buffer numbers that it builds from its own field model. A randomized phase later repeats this with random status lines and random requesters.

// File: rtl/rdbuf_pool_pkg.sv
`timescale 1ns/1ps
package rdbuf_pool_pkg;
  parameter int FIELDS = 8;
  parameter int FLD_W  = 4;
  parameter int MAPS   = 2;
  parameter int ID_W   = 4;
  parameter int OP_W   = 3;

  localparam int BUFS     = FIELDS * MAPS;
  localparam int MAP_W    = FIELDS * FLD_W;
  localparam int CNT_W    = $clog2(BUFS);
  localparam int BUF_IX_W = $clog2(BUFS);
  localparam int FIX_W    = $clog2(FIELDS);
  localparam int SEL_W    = $clog2(MAPS);
  localparam int EN_BIT   = FLD_W - 1;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  localparam logic [OP_W-1:0] OP_CNT_OWN  = OP_W'(0);
  localparam logic [OP_W-1:0] OP_CNT_FREE = OP_W'(1);
  localparam logic [OP_W-1:0] OP_CLAIM    = OP_W'(2);
  localparam logic [OP_W-1:0] OP_RELEASE  = OP_W'(3);
  localparam logic [OP_W-1:0] OP_FLUSH    = OP_W'(4);

  typedef struct packed {
    logic [MAP_W-1:0]  map;
    logic [FIELDS-1:0] hit;
    logic [CNT_W-1:0]  cnt;
    logic              ok;
  } upd_t;

  // enabled owner code: enable bit over the upper id bits
  function automatic logic [FLD_W-1:0] owner_code(input logic [ID_W-1:0] id);
    return {1'b1, id[ID_W-1:1]};
  endfunction

  function automatic logic [CNT_W-1:0] count_free(input logic [MAP_W-1:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < FIELDS; i++)
      if (!m[i*FLD_W + EN_BIT]) n = n + CNT_ONE;
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] count_owned(input logic [MAP_W-1:0] m,
                                                   input logic [FLD_W-1:0] code);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < FIELDS; i++)
      if (m[i*FLD_W +: FLD_W] == code) n = n + CNT_ONE;
    return n;
  endfunction

  function automatic upd_t claim_fields(input logic [MAP_W-1:0] m,
                                        input logic [FLD_W-1:0] code,
                                        input logic [CNT_W-1:0] want);
    upd_t r;
    r.map = m;
    r.hit = '0;
    r.cnt = '0;
    for (int i = 0; i < FIELDS; i++) begin
      if (!m[i*FLD_W + EN_BIT] && (r.cnt < want)) begin
        r.map[i*FLD_W +: FLD_W] = code;
        r.hit[i] = 1'b1;
        r.cnt    = r.cnt + CNT_ONE;
      end
    end
    r.ok = (r.cnt == want);
    return r;
  endfunction

  function automatic upd_t release_fields(input logic [MAP_W-1:0] m,
                                          input logic [FLD_W-1:0] code,
                                          input logic [CNT_W-1:0] want);
    upd_t r;
    r.map = m;
    r.hit = '0;
    r.cnt = '0;
    for (int i = 0; i < FIELDS; i++) begin
      if ((m[i*FLD_W +: FLD_W] == code) && (r.cnt < want)) begin
        r.map[i*FLD_W + EN_BIT] = 1'b0;
        r.hit[i] = 1'b1;
        r.cnt    = r.cnt + CNT_ONE;
      end
    end
    r.ok = (r.cnt == want);
    return r;
  endfunction

  function automatic logic [BUF_IX_W-1:0] lowest_set(input logic [BUFS-1:0] m);
    logic [BUF_IX_W-1:0] r;
    r = '0;
    for (int i = BUFS - 1; i >= 0; i--)
      if (m[i]) r = BUF_IX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/rdbuf_map_bank.sv
`timescale 1ns/1ps
module rdbuf_map_bank
  import rdbuf_pool_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [MAP_W-1:0]           wr_data,
  output logic [MAPS-1:0][MAP_W-1:0] rd_maps
);
  for (genvar g = 0; g < MAPS; g++) begin : g_word
    logic [MAP_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        word_q <= wr_data;
    end
    assign rd_maps[g] = word_q;
  end
endmodule

// File: rtl/rdbuf_op_eval.sv
`timescale 1ns/1ps
module rdbuf_op_eval
  import rdbuf_pool_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [ID_W-1:0]   id,
  input  logic [CNT_W-1:0]  num,
  input  logic [MAP_W-1:0]  map_in,
  output logic [MAP_W-1:0]  map_out,
  output logic [FIELDS-1:0] drain_fields,
  output logic              map_write,
  output logic [CNT_W-1:0]  cnt,
  output logic              ok
);
  logic [FLD_W-1:0] code;
  logic [FIX_W-1:0] flush_fld;
  upd_t             claim_r;
  upd_t             rel_r;

  assign code      = owner_code(id);
  assign flush_fld = num[CNT_W-1 -: FIX_W];
  assign claim_r   = claim_fields(map_in, code, num);
  assign rel_r     = release_fields(map_in, code, num);

  always_comb begin
    map_out      = map_in;
    drain_fields = '0;
    map_write    = 1'b0;
    cnt          = '0;
    ok           = 1'b0;
    case (op)
      OP_CNT_OWN: begin
        cnt = count_owned(map_in, code);
        ok  = 1'b1;
      end
      OP_CNT_FREE: begin
        cnt = count_free(map_in);
        ok  = 1'b1;
      end
      OP_CLAIM: begin
        map_out   = claim_r.map;
        map_write = 1'b1;
        cnt       = claim_r.cnt;
        ok        = claim_r.ok;
      end
      OP_RELEASE: begin
        map_out      = rel_r.map;
        map_write    = 1'b1;
        drain_fields = rel_r.hit;
        cnt          = rel_r.cnt;
        ok           = rel_r.ok;
      end
      OP_FLUSH: begin
        map_out[int'(flush_fld)*FLD_W + EN_BIT] = 1'b0;
        map_write    = 1'b1;
        drain_fields = FIELDS'(1) << flush_fld;
        ok           = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rdbuf_drain_seq.sv
`timescale 1ns/1ps
module rdbuf_drain_seq
  import rdbuf_pool_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [BUFS-1:0]     start_mask,
  input  logic [BUFS-1:0]     st_inuse,
  input  logic [BUFS-1:0]     st_valid,
  output logic [BUFS-1:0]     clr_strobe,
  output logic                fin
);
  typedef enum logic [1:0] {DR_IDLE, DR_WAIT_USE, DR_PULSE, DR_WAIT_DATA} dr_e;

  dr_e                 ph_q, ph_d;
  logic [BUFS-1:0]     pend_q, pend_d;
  logic [BUF_IX_W-1:0] cur_q, cur_d;
  logic [BUFS-1:0]     rest;
  logic                step;

  assign rest = pend_q & ~(BUFS'(1) << cur_q);

  always_comb begin
    ph_d   = ph_q;
    pend_d = pend_q;
    cur_d  = cur_q;
    step   = 1'b0;
    case (ph_q)
      DR_IDLE: begin
        if (start && (start_mask != '0)) begin
          pend_d = start_mask;
          cur_d  = lowest_set(start_mask);
          ph_d   = DR_WAIT_USE;
        end
      end
      DR_WAIT_USE: begin
        if (!st_inuse[cur_q]) begin
          if (st_valid[cur_q]) ph_d = DR_PULSE;
          else                 step = 1'b1;
        end
      end
      DR_PULSE:     ph_d = DR_WAIT_DATA;
      DR_WAIT_DATA: if (!st_valid[cur_q]) step = 1'b1;
      default:      ph_d = DR_IDLE;
    endcase
    if (step) begin
      pend_d = rest;
      if (rest == '0) begin
        ph_d = DR_IDLE;
      end else begin
        cur_d = lowest_set(rest);
        ph_d  = DR_WAIT_USE;
      end
    end
  end

  assign fin        = step && (rest == '0);
  assign clr_strobe = (ph_q == DR_PULSE) ? (BUFS'(1) << cur_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= DR_IDLE;
      pend_q <= '0;
      cur_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      pend_q <= pend_d;
      cur_q  <= cur_d;
    end
  end
endmodule

// File: rtl/rdbuf_pool_alloc.sv
`timescale 1ns/1ps
module rdbuf_pool_alloc
  import rdbuf_pool_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [CNT_W-1:0]  cmd_num,
  output logic              rsp_done,
  output logic [CNT_W-1:0]  rsp_count,
  output logic              rsp_ok,
  input  logic [BUFS-1:0]   buf_inuse,
  input  logic [BUFS-1:0]   buf_valid,
  output logic [BUFS-1:0]   buf_clear
);
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_DRAIN, ST_RESP} st_e;

  st_e                       st_q, st_d;
  logic [OP_W-1:0]           op_q;
  logic [ID_W-1:0]           id_q;
  logic [CNT_W-1:0]          num_q;
  logic [CNT_W-1:0]          cnt_q;
  logic                      ok_q;
  logic [MAP_W-1:0]          hold_q;

  logic [MAPS-1:0][MAP_W-1:0] maps;
  logic [SEL_W-1:0]          map_sel;
  logic [MAP_W-1:0]          cur_map;
  logic [MAP_W-1:0]          ev_map;
  logic [FIELDS-1:0]         ev_fields;
  logic                      ev_write;
  logic [CNT_W-1:0]          ev_cnt;
  logic                      ev_ok;
  logic [BUFS-1:0]           drain_bufs;

  // named internal events, also watched by the checker
  logic                      cmd_accept;
  logic                      exec_now;
  logic                      seq_fin;
  logic                      restore_now;
  logic                      wr_en;
  logic [MAP_W-1:0]          wr_data;

  assign cmd_ready   = (st_q == ST_IDLE);
  assign cmd_accept  = cmd_valid && cmd_ready;
  assign exec_now    = (st_q == ST_EXEC);
  assign map_sel     = (op_q == OP_FLUSH) ? num_q[SEL_W-1:0] : id_q[SEL_W-1:0];
  assign cur_map     = maps[map_sel];
  assign restore_now = (st_q == ST_DRAIN) && seq_fin && (op_q == OP_FLUSH);
  assign wr_en       = (exec_now && ev_write) || restore_now;
  assign wr_data     = restore_now ? hold_q : ev_map;

  // field index f of word w is buffer f*MAPS + w
  always_comb begin
    drain_bufs = '0;
    for (int f = 0; f < FIELDS; f++)
      drain_bufs[f*MAPS + int'(map_sel)] = ev_fields[f];
  end

  rdbuf_map_bank u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (map_sel),
    .wr_data (wr_data),
    .rd_maps (maps)
  );

  rdbuf_op_eval u_eval (
    .op           (op_q),
    .id           (id_q),
    .num          (num_q),
    .map_in       (cur_map),
    .map_out      (ev_map),
    .drain_fields (ev_fields),
    .map_write    (ev_write),
    .cnt          (ev_cnt),
    .ok           (ev_ok)
  );

  rdbuf_drain_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (exec_now),
    .start_mask (drain_bufs),
    .st_inuse   (buf_inuse),
    .st_valid   (buf_valid),
    .clr_strobe (buf_clear),
    .fin        (seq_fin)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (cmd_accept) st_d = ST_EXEC;
      ST_EXEC:  st_d = (drain_bufs != '0) ? ST_DRAIN : ST_RESP;
      ST_DRAIN: if (seq_fin) st_d = ST_RESP;
      ST_RESP:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      id_q   <= '0;
      num_q  <= '0;
      cnt_q  <= '0;
      ok_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (cmd_accept) begin
        op_q  <= cmd_op;
        id_q  <= cmd_id;
        num_q <= cmd_num;
      end
      if (exec_now) begin
        cnt_q  <= ev_cnt;
        ok_q   <= ev_ok;
        hold_q <= cur_map;
      end
    end
  end

  assign rsp_done  = (st_q == ST_RESP);
  assign rsp_count = cnt_q;
  assign rsp_ok    = ok_q;
endmodule

// File: rtl/rdbuf_pool_chk.sv
`timescale 1ns/1ps
module rdbuf_pool_chk
  import rdbuf_pool_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             rsp_done,
  input logic [CNT_W-1:0] rsp_count,
  input logic [BUFS-1:0]  buf_inuse,
  input logic [BUFS-1:0]  buf_valid,
  input logic [BUFS-1:0]  buf_clear,
  input logic             seq_fin
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (cmd_ready && !rsp_done && (buf_clear == '0))); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) rsp_done |-> (rsp_count <= CNT_W'(FIELDS))); // R3
  AST_CLEAR_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(buf_clear)); // R7
  AST_CLEAR_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst) (buf_clear != '0) |-> (($past(buf_inuse) & buf_clear) == '0)); // R7
  AST_CLEAR_HAS_DATA: assert property (@(posedge clk) disable iff (rst) (buf_clear != '0) |-> (($past(buf_valid) & buf_clear) != '0)); // R7
  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (rst) (buf_clear != '0) |=> ((buf_clear & $past(buf_clear)) == '0)); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) (cmd_valid && cmd_ready) |=> !cmd_ready); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done); // R9
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst) rsp_done |-> !cmd_ready); // R9
  AST_NO_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst) cmd_ready |-> (buf_clear == '0)); // R9
  AST_FIN_TO_DONE: assert property (@(posedge clk) disable iff (rst) seq_fin |=> rsp_done); // R9
endmodule

bind rdbuf_pool_alloc rdbuf_pool_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rsp_done  (rsp_done),
  .rsp_count (rsp_count),
  .buf_inuse (buf_inuse),
  .buf_valid (buf_valid),
  .buf_clear (buf_clear),
  .seq_fin   (seq_fin)
);

// File: tb/rdbuf_pool_alloc_tb_top.sv
`timescale 1ns/1ps
module rdbuf_pool_alloc_tb_top;
  import rdbuf_pool_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [3:0]  cmd_id = '0;
  logic [3:0]  cmd_num = '0;
  logic        rsp_done;
  logic [3:0]  rsp_count;
  logic        rsp_ok;
  logic [15:0] inuse_r = '0;
  logic [15:0] valid_r = '0;
  logic [15:0] buf_clear;

  int total = 0;
  int bad = 0;
  int fv[16];
  int inuse_t[16];
  int vdrop[16];
  int expq[$];
  bit busy_exp = 0;

  always #10 clk = ~clk;

  rdbuf_pool_alloc dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_num(cmd_num),
    .rsp_done(rsp_done), .rsp_count(rsp_count), .rsp_ok(rsp_ok),
    .buf_inuse(inuse_r), .buf_valid(valid_r), .buf_clear(buf_clear)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: sample away from the edge, play the buffer status side
  task automatic tick();
    @(negedge clk);
    if (buf_clear != '0) begin
      int b;
      b = 0;
      for (int i = 0; i < 16; i++) if (buf_clear[i]) b = i;
      chk("R7", "clear strobe width", $countones(buf_clear), 1);
      if (expq.size() == 0) chk("R7", "unexpected clear of buffer", b, -1);
      else begin
        chk("R7", "clear order", b, expq[0]);
        void'(expq.pop_front());
      end
      chk("R7", "clear while in use", int'(inuse_r[b]), 0);
      chk("R7", "clear without data", int'(valid_r[b]), 1);
      vdrop[b] = 3;
    end
    if (busy_exp) chk("R9", "ready while busy", int'(cmd_ready), 0);
    else if (rsp_done) chk("R9", "stray done", 1, 0);
    for (int i = 0; i < 16; i++) begin
      if (inuse_t[i] > 0) begin
        inuse_t[i]--;
        if (inuse_t[i] == 0) inuse_r[i] = 1'b0;
      end
      if (vdrop[i] > 0) begin
        vdrop[i]--;
        if (vdrop[i] == 0) valid_r[i] = 1'b0;
      end
    end
  endtask

  task automatic do_cmd(input int op, input int id, input int num, input string req);
    int sel, code, ec, lat;
    bit eok, drain;
    sel = (op == 4) ? (num % 2) : (id % 2);
    code = 8 + id / 2;
    ec = 0; eok = 1; drain = 0;
    case (op)
      0: for (int b = sel; b < 16; b += 2) if (fv[b] == code) ec++;
      1: for (int b = sel; b < 16; b += 2) if (fv[b] < 8) ec++;
      2: begin
        for (int b = sel; b < 16; b += 2)
          if (fv[b] < 8 && ec < num) begin fv[b] = code; ec++; end
        eok = (ec == num);
      end
      3: begin
        for (int b = sel; b < 16; b += 2)
          if (fv[b] == code && ec < num) begin
            fv[b] -= 8; ec++; drain = 1;
            if (valid_r[b]) expq.push_back(b);
          end
        eok = (ec == num);
      end
      4: begin
        drain = 1;
        if (valid_r[num]) expq.push_back(num);
      end
      default: eok = 0;
    endcase
    cmd_op = 3'(op); cmd_id = 4'(id); cmd_num = 4'(num); cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
    busy_exp = 1;
    lat = 1;
    while (!rsp_done && lat < 400) begin
      tick();
      lat++;
    end
    chk("R9", "done seen", int'(rsp_done), 1);
    if (!drain) chk("R9", "done latency", lat, 2);
    chk(req, "count", int'(rsp_count), ec);
    chk(req, "ok flag", int'(rsp_ok), int'(eok));
    chk("R7", "pending clears left", expq.size(), 0);
    expq.delete();
    busy_exp = 0;
    tick();
    chk("R9", "ready after done", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    $display("FAIL R9 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    for (int b = 0; b < 16; b++) begin fv[b] = 0; inuse_t[b] = 0; vdrop[b] = 0; end
    repeat (3) tick();
    chk("R1", "ready in reset", int'(cmd_ready), 1);
    chk("R1", "done in reset", int'(rsp_done), 0);
    chk("R1", "clear in reset", int'(buf_clear), 0);
    rst = 1'b0;
    tick();
    do_cmd(1, 0, 0, "R1");            // word 0 all free
    do_cmd(1, 1, 0, "R1");            // word 1 all free
    do_cmd(2, 0, 3, "R5");            // b0 b2 b4 code 8
    do_cmd(2, 9, 2, "R5");            // b1 b3 code 12
    do_cmd(2, 2, 2, "R5");            // b6 b8 code 9
    do_cmd(0, 0, 0, "R4");            // 3
    do_cmd(0, 2, 0, "R4");            // 2
    do_cmd(0, 8, 0, "R2");            // virtual slot 0 owns none in word 0
    do_cmd(0, 1, 0, "R2");            // word 1 code 8 owns none
    do_cmd(0, 9, 0, "R2");            // 2
    do_cmd(1, 0, 0, "R3");            // 3 free
    do_cmd(1, 1, 0, "R3");            // 6 free
    do_cmd(2, 4, 6, "R5");            // only 3 claimable, fail
    do_cmd(1, 0, 0, "R3");            // 0 free
    // mixed drain: b0 has data, b2 in flight without data, b4 in flight with data
    valid_r[0] = 1'b1; valid_r[4] = 1'b1;
    inuse_r[2] = 1'b1; inuse_t[2] = 3;
    inuse_r[4] = 1'b1; inuse_t[4] = 9;
    do_cmd(3, 0, 5, "R6");            // 3 released, fail, clears b0 then b4
    do_cmd(0, 0, 0, "R6");            // 0
    do_cmd(1, 0, 0, "R3");            // 3
    do_cmd(2, 6, 1, "R5");            // takes lowest: b0
    valid_r[0] = 1'b1;
    do_cmd(3, 6, 1, "R5");            // strobe on b0 proves placement
    valid_r[6] = 1'b1; valid_r[8] = 1'b1;
    do_cmd(3, 2, 1, "R6");            // only b6
    do_cmd(0, 2, 0, "R6");            // 1 left
    valid_r[1] = 1'b1;
    do_cmd(4, 0, 1, "R8");            // flush owned b1
    do_cmd(0, 9, 0, "R8");            // still 2
    valid_r[15] = 1'b1;
    do_cmd(4, 0, 15, "R8");           // flush free b15
    do_cmd(1, 1, 0, "R8");            // still 6 free
    do_cmd(5, 0, 2, "R10");
    do_cmd(7, 3, 4, "R10");
    do_cmd(1, 0, 0, "R10");           // unchanged
    do_cmd(2, 3, 0, "R5");            // N = 0 passes
    do_cmd(3, 7, 2, "R6");            // owns none: fail, no drain
    for (int k = 0; k < 80; k++) begin
      for (int b = 0; b < 16; b++)
        if (inuse_t[b] == 0 && vdrop[b] == 0) begin
          valid_r[b] = 1'($urandom_range(0, 1));
          if ($urandom_range(0, 3) == 0) begin
            inuse_r[b] = 1'b1;
            inuse_t[b] = int'($urandom_range(1, 5));
          end
        end
      do_cmd(int'($urandom_range(0, 5)), int'($urandom_range(0, 15)),
             int'($urandom_range(0, 9)), "R5");
    end
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    for (int b = 0; b < 16; b++) fv[b] = 0;
    tick();
    do_cmd(1, 0, 0, "R1");
    do_cmd(1, 1, 0, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule